// File: doc/BRIEF.md
# Pipelined Odd/Even Karatsuba Multiplier over GF(3^m)

This block multiplies two elements of the ternary extension field GF(3^m) and returns their product reduced modulo a fixed irreducible trinomial. Each operand is a polynomial of degree at most m-1 whose coefficients (trits) take the values 0, 1 or 2. The full polynomial product is built by recursive Karatsuba-Ofman splitting. At each level the operands are split by coefficient index parity, into even-index and odd-index halves, and not into low and high halves. Because of this, the three partial products recombine without overlapping. The recursion stops after a configurable number of levels, and schoolbook multipliers finish the work at the leaves. A linear-cost folding stage then reduces the product of degree 2m-2 modulo f(x) = x^m + F_K·x^K + F0.

Registers separate every split level, the leaf products, every recombination level, and the reduction. The block therefore accepts a new operand pair on every clock cycle, and each result leaves a fixed number of cycles later. A valid flag travels with the data. It is intended as the shared field-multiply engine of a larger datapath that issues independent products back to back.

Top module: `gf3m_kom_mul`

## Requirements
- R1: Trit i of a port occupies bits [2i+1:2i] and is encoded 00 = 0, 01 = 1, 10 = 2. While out_valid is high, no output trit carries the code 11.
- R2: For default parameters (m = 97, f(x) = x^97 + x^12 + 2), out_c equals in_a·in_b mod f(x) over GF(3), for arbitrary operand values.
- R3: With default parameters (two split levels), out_valid rises exactly 7 cycles after in_valid is sampled high. Inputs on consecutive cycles produce results on consecutive cycles, one per cycle.
- R4: A cycle with in_valid low produces a cycle with out_valid low 7 cycles later, even when valid inputs surround it.
- R5: A synchronous active-high rst clears every valid flag in the pipeline. out_valid is low in the cycle after rst and stays low until a valid input issued after reset has travelled through, so in-flight products are dropped.
- R6: A zero operand in either position gives an all-zero product.
- R7: When one operand is the constant 1 (trit 0 = 01, all others 00), the product equals the other operand.
- R8: Terms of degree m through 2m-2 are folded correctly. This includes x^(m-1)·x^(m-1), x^(m-1)·x (giving x^K·(-F_K) + (-F0), i.e. 2x^12 + 1 by default), and operands with every trit equal to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Operand pair on in_a/in_b is issued this cycle |
| in_a | input | 2*M | First operand, M trits of two bits each |
| in_b | input | 2*M | Second operand, M trits of two bits each |
| out_valid | output | 1 | out_c holds a finished product |
| out_c | output | 2*M | Reduced product, M trits of two bits each |

## Verification
An operand pair driven before a rising edge passes through the input register, two split registers, the leaf register, two recombination registers and the reduction register. Its result is therefore visible after the seventh edge, counting the sampling edge. The bench drives every input at a falling edge and files the expected result in a slot of an eight-entry ring indexed by cycle number. Each cycle it first compares the ports against the entry written seven cycles earlier, and only then files the new one. Bubbles, the results of the directed corner operands, and the flush after a mid-stream reset are all read at that same seven-cycle offset.

// File: rtl/gf3m_pkg.sv
package gf3m_pkg;

  // trit codes: 2'b00 = 0, 2'b01 = 1, 2'b10 = 2
  function automatic logic [1:0] t_add(input logic [1:0] x, input logic [1:0] y);
    logic [2:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s >= 3'd3) s = s - 3'd3;
    return s[1:0];
  endfunction

  function automatic logic [1:0] t_neg(input logic [1:0] x);
    return (x == 2'd0) ? 2'd0 : (2'd3 - x);
  endfunction

  function automatic logic [1:0] t_sub(input logic [1:0] x, input logic [1:0] y);
    return t_add(x, t_neg(y));
  endfunction

  // 1*1 = 1, 2*2 = 4 = 1, 1*2 = 2
  function automatic logic [1:0] t_mul(input logic [1:0] x, input logic [1:0] y);
    if (x == 2'd0 || y == 2'd0) return 2'd0;
    return (x == y) ? 2'd1 : 2'd2;
  endfunction

endpackage

// File: rtl/gf3_school_leaf.sv
module gf3_school_leaf
  import gf3m_pkg::*;
#(
  parameter int N = 25
) (
  input  logic                  clk,
  input  logic [N-1:0][1:0]     a,
  input  logic [N-1:0][1:0]     b,
  output logic [2*N-2:0][1:0]   c
);

  logic [2*N-2:0][1:0] acc;

  // quadratic schoolbook product, no carries between trits
  always_comb begin
    acc = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        acc[i+j] = t_add(acc[i+j], t_mul(a[i], b[j]));
      end
    end
  end

  always_ff @(posedge clk) c <= acc;

endmodule

// File: rtl/gf3_kom_node.sv
module gf3_kom_node
  import gf3m_pkg::*;
#(
  parameter int N      = 97,
  parameter int LEVELS = 2
) (
  input  logic                  clk,
  input  logic [N-1:0][1:0]     a,
  input  logic [N-1:0][1:0]     b,
  output logic [2*N-2:0][1:0]   c
);

  // latency of this node: 2*LEVELS + 1 cycles
  generate
    if (LEVELS == 0) begin : g_leaf
      gf3_school_leaf #(.N(N)) u_leaf (.clk(clk), .a(a), .b(b), .c(c));
    end else begin : g_split
      localparam int H  = (N + 1) / 2;
      localparam int CW = 2 * N - 1;
      localparam int HW = 2 * H - 1;

      logic [2*H-1:0][1:0] a_pad, b_pad;
      logic [H-1:0][1:0]   ae_q, ao_q, as_q, be_q, bo_q, bs_q;
      logic [HW-1:0][1:0]  e_c, o_c, m_c;
      logic [CW-1:0][1:0]  rec;

      always_comb begin
        a_pad = '0;
        b_pad = '0;
        a_pad[N-1:0] = a;
        b_pad[N-1:0] = b;
      end

      // split by index parity and form the middle operands
      always_ff @(posedge clk) begin
        for (int i = 0; i < H; i++) begin
          ae_q[i] <= a_pad[2*i];
          ao_q[i] <= a_pad[2*i+1];
          as_q[i] <= t_add(a_pad[2*i], a_pad[2*i+1]);
          be_q[i] <= b_pad[2*i];
          bo_q[i] <= b_pad[2*i+1];
          bs_q[i] <= t_add(b_pad[2*i], b_pad[2*i+1]);
        end
      end

      gf3_kom_node #(.N(H), .LEVELS(LEVELS-1)) u_even (.clk(clk), .a(ae_q), .b(be_q), .c(e_c));
      gf3_kom_node #(.N(H), .LEVELS(LEVELS-1)) u_odd  (.clk(clk), .a(ao_q), .b(bo_q), .c(o_c));
      gf3_kom_node #(.N(H), .LEVELS(LEVELS-1)) u_mid  (.clk(clk), .a(as_q), .b(bs_q), .c(m_c));

      // even slots take E and shifted O, odd slots take M - E - O: no overlap
      always_comb begin
        rec = '0;
        for (int i = 0; i < HW; i++) begin
          if (2*i < CW)     rec[2*i]   = t_add(rec[2*i], e_c[i]);
          if (2*i + 2 < CW) rec[2*i+2] = t_add(rec[2*i+2], o_c[i]);
          if (2*i + 1 < CW) rec[2*i+1] = t_sub(t_sub(m_c[i], e_c[i]), o_c[i]);
        end
      end

      always_ff @(posedge clk) c <= rec;
    end
  endgenerate

endmodule

// File: rtl/gf3_trinom_reduce.sv
module gf3_trinom_reduce
  import gf3m_pkg::*;
#(
  parameter int         M   = 97,
  parameter int         K   = 12,
  parameter logic [1:0] F_K = 2'd1,
  parameter logic [1:0] F0  = 2'd2
) (
  input  logic [2*M-2:0][1:0] full,
  output logic [M-1:0][1:0]   red
);

  logic [2*M-2:0][1:0] w;

  // x^k = -F_K*x^(k-M+K) - F0*x^(k-M); top-down so refolded terms are caught
  always_comb begin
    w = full;
    for (int k = 2*M-2; k >= M; k--) begin
      w[k-M+K] = t_sub(w[k-M+K], t_mul(F_K, w[k]));
      w[k-M]   = t_sub(w[k-M],   t_mul(F0,  w[k]));
    end
    red = w[M-1:0];
  end

endmodule

// File: rtl/gf3m_kom_mul.sv
module gf3m_kom_mul
  import gf3m_pkg::*;
#(
  parameter int         M      = 97,
  parameter int         K      = 12,
  parameter logic [1:0] F_K    = 2'd1,
  parameter logic [1:0] F0     = 2'd2,
  parameter int         LEVELS = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [2*M-1:0] in_a,
  input  logic [2*M-1:0] in_b,
  output logic           out_valid,
  output logic [2*M-1:0] out_c
);

  localparam int DEPTH = 2 * LEVELS + 3;

  logic [DEPTH-1:0]    vld_q;
  logic [M-1:0][1:0]   a_q, b_q, red, c_q;
  logic [2*M-2:0][1:0] prod_full;

  // valid flags are the only reset state
  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[DEPTH-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    a_q <= in_a;
    b_q <= in_b;
  end

  gf3_kom_node #(.N(M), .LEVELS(LEVELS)) u_tree (
    .clk(clk), .a(a_q), .b(b_q), .c(prod_full)
  );

  gf3_trinom_reduce #(.M(M), .K(K), .F_K(F_K), .F0(F0)) u_red (
    .full(prod_full), .red(red)
  );

  always_ff @(posedge clk) c_q <= red;

  assign out_valid = vld_q[DEPTH-1];
  assign out_c     = c_q;

endmodule

// File: rtl/gf3m_kom_mul_chk.sv
module gf3m_kom_mul_chk #(
  parameter int M   = 97,
  parameter int LAT = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [2*M-1:0] in_a,
  input logic [2*M-1:0] in_b,
  input logic           out_valid,
  input logic [2*M-1:0] out_c
);

  localparam logic [2*M-1:0] ONE = {{(2*M-2){1'b0}}, 2'b01};

  logic [LAT-1:0] v_sh, z_sh, o_sh;
  logic [2*M-1:0] b_sh [LAT];

  always_ff @(posedge clk) begin
    if (rst) v_sh <= '0;
    else     v_sh <= {v_sh[LAT-2:0], in_valid};
    z_sh <= {z_sh[LAT-2:0], (in_a == '0) || (in_b == '0)};
    o_sh <= {o_sh[LAT-2:0], (in_a == ONE)};
    b_sh[0] <= in_b;
    for (int i = 1; i < LAT; i++) b_sh[i] <= b_sh[i-1];
  end

  function automatic logic trits_ok(input logic [2*M-1:0] v);
    for (int i = 0; i < M; i++) if (v[2*i+:2] == 2'b11) return 1'b0;
    return 1'b1;
  endfunction

  assert_codes_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> trits_ok(out_c));

  // R3 and R4: the output flag follows the issue flag at the fixed offset
  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid == v_sh[LAT-1]);

  assert_flush_R5: assert property (@(posedge clk)
    rst |=> !out_valid);

  assert_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && z_sh[LAT-1]) |-> (out_c == '0));

  assert_unit_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && o_sh[LAT-1]) |-> (out_c == b_sh[LAT-1]));

endmodule

bind gf3m_kom_mul gf3m_kom_mul_chk #(.M(M), .LAT(2*LEVELS+3)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
  .out_valid(out_valid), .out_c(out_c)
);

// File: tb/gf3m_kom_mul_tb.sv
`timescale 1ns/1ps
module gf3m_kom_mul_tb_top;

  localparam int M    = 97;
  localparam int K    = 12;
  localparam int FK   = 1;
  localparam int FC   = 2;
  localparam int LAT  = 7;
  localparam int NRUN = 160;

  logic           clk = 1'b0;
  logic           rst;
  logic           in_valid;
  logic [2*M-1:0] in_a, in_b;
  logic           out_valid;
  logic [2*M-1:0] out_c;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;

  logic [2*M-1:0] exp_q [8];
  logic           v_q   [8];
  string          tag_q [8];

  always #2 clk = ~clk;

  gf3m_kom_mul dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_c(out_c)
  );

  // Horner form: r = r*x mod f, then add a_i*b; independent of the tree
  function automatic logic [2*M-1:0] ref_mul(input logic [2*M-1:0] a, input logic [2*M-1:0] b);
    int r [M];
    int top, ai;
    logic [2*M-1:0] res;
    for (int k = 0; k < M; k++) r[k] = 0;
    for (int i = M-1; i >= 0; i--) begin
      top = r[M-1];
      for (int k = M-1; k > 0; k--) r[k] = r[k-1];
      r[0] = 0;
      r[K] = (r[K] + 3 * 3 - FK * top) % 3;
      r[0] = (r[0] + 3 * 3 - FC * top) % 3;
      ai = int'(a[2*i+:2]);
      for (int j = 0; j < M; j++) r[j] = (r[j] + ai * int'(b[2*j+:2])) % 3;
    end
    for (int k = 0; k < M; k++) res[2*k+:2] = 2'(r[k]);
    return res;
  endfunction

  function automatic logic [2*M-1:0] rand_op();
    logic [2*M-1:0] v;
    for (int i = 0; i < M; i++) v[2*i+:2] = 2'($urandom % 3);
    return v;
  endfunction

  function automatic logic [2*M-1:0] mono(input int d, input int c);
    logic [2*M-1:0] v = '0;
    v[2*d+:2] = 2'(c);
    return v;
  endfunction

  function automatic logic [2*M-1:0] all_two();
    logic [2*M-1:0] v;
    for (int i = 0; i < M; i++) v[2*i+:2] = 2'b10;
    return v;
  endfunction

  task automatic check_slot(input int slot);
    n_tests++;
    if (out_valid !== v_q[slot]) begin
      n_fail++;
      $display("FAIL %s R3 out_valid actual %0b expected %0b", tag_q[slot], out_valid, v_q[slot]);
    end else if (v_q[slot] && out_c !== exp_q[slot]) begin
      n_fail++;
      $display("FAIL %s R2 out_c actual %h expected %h", tag_q[slot], out_c, exp_q[slot]);
    end
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog R3 actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4242));
    rst = 1'b1; in_valid = 1'b0; in_a = '0; in_b = '0;
    for (int s = 0; s < 8; s++) begin v_q[s] = 1'b0; exp_q[s] = '0; tag_q[s] = "R4"; end
    repeat (3) @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R5 reset out_valid actual %0b expected 0", out_valid);
    end
    rst = 1'b0;

    for (int n = 0; n < NRUN + LAT + 1; n++) begin
      @(negedge clk);
      check_slot((n + 1) % 8);
      in_valid = 1'b0;
      if (n < NRUN) begin
        string t;
        logic v;
        v = 1'b1;
        t = "R2";
        in_a = rand_op();
        in_b = rand_op();
        case (n)
          0: begin in_a = '0;              t = "R6"; end
          1: begin in_a = mono(0, 1);      t = "R7"; end
          2: begin in_b = mono(0, 1);      t = "R7"; end
          3: begin in_a = all_two(); in_b = all_two(); t = "R8"; end
          4: begin in_a = mono(M-1, 1); in_b = mono(M-1, 1); t = "R8"; end
          5: begin v = 1'b0;               t = "R4"; end
          6: begin in_b = '0;              t = "R6"; end
          7: begin in_a = mono(M-1, 1); in_b = mono(1, 1); t = "R8"; end
          8: begin in_a = mono(M-1, 2); in_b = all_two(); t = "R8"; end
          default: if ($urandom % 7 == 0) begin v = 1'b0; t = "R4"; end
        endcase
        in_valid = v;
        v_q[n % 8]   = v;
        exp_q[n % 8] = ref_mul(in_a, in_b);
        tag_q[n % 8] = t;
      end else begin
        v_q[n % 8]   = 1'b0;
        tag_q[n % 8] = "R4";
      end
    end

    // R5: products in flight when reset arrives are dropped
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      in_valid = 1'b1; in_a = rand_op(); in_b = rand_op();
    end
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int n = 0; n < LAT + 1; n++) begin
      n_tests++;
      if (out_valid !== 1'b0) begin
        n_fail++;
        $display("FAIL R5 flush cycle %0d out_valid actual %0b expected 0", n, out_valid);
      end
      @(negedge clk);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule